// File: doc/BRIEF.md
# Eight-Channel Capture/Compare Timer

This block is a 16-bit free-running counter shared by eight channels. A power-of-two prescaler sets how often the counter advances. Software makes each channel an input capture or an output compare. A capture channel watches its pin for a chosen edge. When that edge arrives it stores the counter value and raises its flag. A compare channel drives its pin. When the counter reaches the channel's register value, the channel applies a chosen output action and raises its flag.

Channel 7 also acts as a master event. When its compare succeeds, a masked group of channels is forced to preset output levels. A counter wrap raises an overflow flag, and it can also toggle chosen compare outputs. Flags are cleared by writing ones to them, and only while the timer runs.

Software reaches all of this through a small synchronous register bus. The bus has a write strobe and a combinational read port. Each channel pin is split into an input, an output and an output enable.

Top module: `cc_timer`

## Requirements
- R1: After synchronous reset the counter, every register, all flags, `ch_out` and `ch_oe` read as zero.
- R2: CTRL (address 0) holds the enable in bit 0 and a divide field PS in bits [3:1]. While enabled, the counter advances once every 2^PS clocks. While disabled, the counter holds its value and the prescaler restarts.
- R3: When the counter advances from 0xFFFF to 0x0000, overflow flag bit 8 of FLAGS (address 6) is set. It is also driven on `ovf_flag`.
- R4: A channel in capture mode (bit i of MODE, address 1, is 0) passes its pin through two sampling registers. The EDGE register (address 2) holds a select field for each channel in bits [2i+1:2i]: 00 none, 01 rising, 10 falling, 11 either. On a selected edge, while the timer is enabled, the channel stores the current counter value in its channel register (address 8+i) and sets flag bit i. Edges that are not selected change nothing.
- R5: A channel in compare mode (MODE bit i = 1) has `ch_oe[i]` high. When a prescaler tick takes the counter to the channel register value, the channel sets flag bit i on the same clock edge that updates the counter.
- R6: On a compare match, the action field of channel i in ACTION (address 3, bits [2i+1:2i]) acts on `ch_out[i]`: 00 leaves it, 01 toggles it, 10 drives it 0, 11 drives it 1.
- R7: A compare match on channel 7 forces each compare-mode channel whose bit is set in OVR[7:0] (address 4) to the level in OVR bit 8+i. This takes priority over that channel's own action.
- R8: Writing 1 to a FLAGS bit clears that bit only while the timer is enabled. While the timer is disabled, the write leaves the flags unchanged.
- R9: When bit i of TOGOVF (address 5) is set, a counter wrap toggles the output of compare channel i. This has lower priority than an override or an own compare action.
- R10: Every register reads back what was last written: CTRL [3:0], MODE [7:0], EDGE [15:0], ACTION [15:0], OVR [15:0], TOGOVF [7:0] and the channel registers [15:0]. COUNT (address 7) reads the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| ch_in | input | 8 | Channel pin input levels |
| ch_out | output | 8 | Channel pin output levels |
| ch_oe | output | 8 | Channel pin output enables (compare mode) |
| ch_flags | output | 8 | Channel event flags |
| ovf_flag | output | 1 | Counter overflow flag |

## Verification
The assertions assume that the bus never writes a channel register in the same cycle as a capture on that channel. They also assume that pin levels change only between clock edges. The bench keeps to both: it writes a capture channel's register only while no edge is pending, and it drives pins and bus signals on falling clock edges. The bench chooses compare values a few dozen counts ahead of the live counter, so every awaited match arrives within a bounded wait.

// File: rtl/cct_pkg.sv
package cct_pkg;

    localparam int NCH  = 8;
    localparam int DW   = 16;
    localparam int AW   = 4;
    localparam int PSW  = 3;
    localparam int CHIW = $clog2(NCH);

    localparam logic [AW-1:0] A_CTRL   = 4'd0;
    localparam logic [AW-1:0] A_MODE   = 4'd1;
    localparam logic [AW-1:0] A_EDGE   = 4'd2;
    localparam logic [AW-1:0] A_ACT    = 4'd3;
    localparam logic [AW-1:0] A_OVR    = 4'd4;
    localparam logic [AW-1:0] A_TOGOVF = 4'd5;
    localparam logic [AW-1:0] A_FLAGS  = 4'd6;
    localparam logic [AW-1:0] A_COUNT  = 4'd7;
    localparam int            A_CH0    = 8;

    typedef enum logic [1:0] {
        EDG_OFF  = 2'b00,
        EDG_RISE = 2'b01,
        EDG_FALL = 2'b10,
        EDG_ANY  = 2'b11
    } edge_sel_e;

    typedef enum logic [1:0] {
        ACT_KEEP = 2'b00,
        ACT_TOG  = 2'b01,
        ACT_LOW  = 2'b10,
        ACT_HIGH = 2'b11
    } out_act_e;

    typedef struct packed {
        logic [PSW-1:0] ps;
        logic           en;
    } ctrl_t;

    function automatic logic edge_hit(edge_sel_e sel, logic now, logic prev);
        case (sel)
            EDG_RISE: return now & ~prev;
            EDG_FALL: return ~now & prev;
            EDG_ANY:  return now ^ prev;
            default:  return 1'b0;
        endcase
    endfunction

    function automatic logic act_apply(out_act_e act, logic cur);
        case (act)
            ACT_TOG:  return ~cur;
            ACT_LOW:  return 1'b0;
            ACT_HIGH: return 1'b1;
            default:  return cur;
        endcase
    endfunction

endpackage

// File: rtl/cct_timebase.sv
module cct_timebase
    import cct_pkg::*;
#(
    parameter int CW = DW,
    parameter int PW = PSW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [PW-1:0] ps,
    output logic          tick,
    output logic          wrap,
    output logic [CW-1:0] cnt
);
    localparam int DIVW = (1 << PW) - 1;

    logic [DIVW-1:0] psc_q;
    logic [DIVW-1:0] mask;

    always_comb begin
        mask = DIVW'(((DIVW+1)'(1) << ps) - (DIVW+1)'(1));
        tick = en && ((psc_q & mask) == mask);
        wrap = tick && (cnt == {CW{1'b1}});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            psc_q <= '0;
            cnt   <= '0;
        end else begin
            psc_q <= en ? psc_q + DIVW'(1) : '0;
            if (tick)
                cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/cct_channel.sv
module cct_channel
    import cct_pkg::*;
#(
    parameter int CW = DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          tick,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] cnt_next,
    input  logic          cmp_mode,
    input  edge_sel_e     edge_sel,
    input  out_act_e      act,
    input  logic          pin_in,
    input  logic          wr_val,
    input  logic [CW-1:0] wdata,
    input  logic          ovf_evt,
    input  logic          tog_ovf,
    input  logic          ovr_evt,
    input  logic          ovr_sel,
    input  logic          ovr_lvl,
    output logic [CW-1:0] val,
    output logic          match,
    output logic          evt,
    output logic          pin_out
);
    logic pin_q, pin_qq;
    logic capture;

    always_comb begin
        match   = cmp_mode && tick && (cnt_next == val);
        capture = en && !cmp_mode && edge_hit(edge_sel, pin_q, pin_qq);
        evt     = match | capture;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q   <= 1'b0;
            pin_qq  <= 1'b0;
            val     <= '0;
            pin_out <= 1'b0;
        end else begin
            pin_q  <= pin_in;
            pin_qq <= pin_q;
            if (capture)
                val <= cnt;
            else if (wr_val)
                val <= wdata;
            if (cmp_mode) begin
                if (ovr_evt && ovr_sel)
                    pin_out <= ovr_lvl;
                else if (match)
                    pin_out <= act_apply(act, pin_out);
                else if (ovf_evt && tog_ovf)
                    pin_out <= ~pin_out;
            end
        end
    end
endmodule

// File: rtl/cc_timer.sv
module cc_timer
    import cct_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [AW-1:0]  bus_addr,
    input  logic           bus_wr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    input  logic [NCH-1:0] ch_in,
    output logic [NCH-1:0] ch_out,
    output logic [NCH-1:0] ch_oe,
    output logic [NCH-1:0] ch_flags,
    output logic           ovf_flag
);
    ctrl_t              ctrl_q;
    logic [NCH-1:0]     mode_q;
    logic [2*NCH-1:0]   edge_q;
    logic [2*NCH-1:0]   act_q;
    logic [NCH-1:0]     ovr_mask;
    logic [NCH-1:0]     ovr_val;
    logic [NCH-1:0]     tog_q;

    logic               tick, wrap;
    logic [DW-1:0]      cnt, cnt_next;
    logic [DW-1:0]      ch_val [NCH];
    logic [NCH-1:0]     ch_match, ch_evt;
    logic               ovr_evt;
    logic [NCH-1:0]     flag_clr;
    logic               ovf_clr;

    function automatic logic wr_at(logic [AW-1:0] a);
        return bus_wr && (bus_addr == a);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            mode_q   <= '0;
            edge_q   <= '0;
            act_q    <= '0;
            ovr_mask <= '0;
            ovr_val  <= '0;
            tog_q    <= '0;
        end else begin
            if (wr_at(A_CTRL))   ctrl_q <= ctrl_t'(bus_wdata[PSW:0]);
            if (wr_at(A_MODE))   mode_q <= bus_wdata[NCH-1:0];
            if (wr_at(A_EDGE))   edge_q <= bus_wdata[2*NCH-1:0];
            if (wr_at(A_ACT))    act_q  <= bus_wdata[2*NCH-1:0];
            if (wr_at(A_TOGOVF)) tog_q  <= bus_wdata[NCH-1:0];
            if (wr_at(A_OVR)) begin
                ovr_mask <= bus_wdata[NCH-1:0];
                ovr_val  <= bus_wdata[2*NCH-1:NCH];
            end
        end
    end

    cct_timebase #(.CW(DW), .PW(PSW)) u_tb (
        .clk  (clk),
        .rst  (rst),
        .en   (ctrl_q.en),
        .ps   (ctrl_q.ps),
        .tick (tick),
        .wrap (wrap),
        .cnt  (cnt)
    );

    assign cnt_next = cnt + DW'(1);
    assign ovr_evt  = ch_match[NCH-1];

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        cct_channel #(.CW(DW)) u_ch (
            .clk      (clk),
            .rst      (rst),
            .en       (ctrl_q.en),
            .tick     (tick),
            .cnt      (cnt),
            .cnt_next (cnt_next),
            .cmp_mode (mode_q[g]),
            .edge_sel (edge_sel_e'(edge_q[2*g +: 2])),
            .act      (out_act_e'(act_q[2*g +: 2])),
            .pin_in   (ch_in[g]),
            .wr_val   (wr_at(AW'(A_CH0 + g))),
            .wdata    (bus_wdata),
            .ovf_evt  (wrap),
            .tog_ovf  (tog_q[g]),
            .ovr_evt  (ovr_evt),
            .ovr_sel  (ovr_mask[g]),
            .ovr_lvl  (ovr_val[g]),
            .val      (ch_val[g]),
            .match    (ch_match[g]),
            .evt      (ch_evt[g]),
            .pin_out  (ch_out[g])
        );
    end

    assign ch_oe = mode_q;

    always_comb begin
        flag_clr = '0;
        ovf_clr  = 1'b0;
        if (wr_at(A_FLAGS) && ctrl_q.en) begin
            flag_clr = bus_wdata[NCH-1:0];
            ovf_clr  = bus_wdata[NCH];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ch_flags <= '0;
            ovf_flag <= 1'b0;
        end else begin
            ch_flags <= (ch_flags & ~flag_clr) | ch_evt;
            ovf_flag <= (ovf_flag & ~ovf_clr) | wrap;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr[AW-1]) begin
            bus_rdata = ch_val[bus_addr[CHIW-1:0]];
        end else begin
            case (bus_addr)
                A_CTRL:   bus_rdata = DW'(ctrl_q);
                A_MODE:   bus_rdata = DW'(mode_q);
                A_EDGE:   bus_rdata = edge_q;
                A_ACT:    bus_rdata = act_q;
                A_OVR:    bus_rdata = {ovr_val, ovr_mask};
                A_TOGOVF: bus_rdata = DW'(tog_q);
                A_FLAGS:  bus_rdata = DW'({ovf_flag, ch_flags});
                A_COUNT:  bus_rdata = cnt;
                default:  bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/cct_checker.sv
module cct_checker
    import cct_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           enable,
    input logic           tick,
    input logic [DW-1:0]  cnt,
    input logic           ovf_flag,
    input logic [NCH-1:0] flags,
    input logic           ovr_evt,
    input logic [NCH-1:0] ovr_mask,
    input logic [NCH-1:0] ovr_val,
    input logic [NCH-1:0] mode,
    input logic [NCH-1:0] ch_out
);
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        tick |=> (cnt == DW'($past(cnt) + DW'(1))));                        // R2
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt));                                            // R2
    AST_OVF_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt == {DW{1'b1}}) |=> ovf_flag);                          // R3
    AST_FLAGS_FROZEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !enable |=> ($stable(flags) && $stable(ovf_flag)));                 // R8
    AST_OVERRIDE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        ovr_evt |=> (((ch_out ^ $past(ovr_val)) & $past(ovr_mask & mode)) == '0)); // R7
endmodule

bind cc_timer cct_checker u_cct_checker (
    .clk      (clk),
    .rst      (rst),
    .enable   (ctrl_q.en),
    .tick     (tick),
    .cnt      (cnt),
    .ovf_flag (ovf_flag),
    .flags    (ch_flags),
    .ovr_evt  (ovr_evt),
    .ovr_mask (ovr_mask),
    .ovr_val  (ovr_val),
    .mode     (mode_q),
    .ch_out   (ch_out)
);

// File: tb/test_cc_timer.sv
`timescale 1ns/1ps
module test_cc_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [7:0]  ch_in = '0;
    logic [7:0]  ch_out, ch_oe, ch_flags;
    logic        ovf_flag;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    cc_timer i_cc_timer (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch_in(ch_in),
        .ch_out(ch_out), .ch_oe(ch_oe), .ch_flags(ch_flags), .ovf_flag(ovf_flag)
    );

    // Reference model built from the requirements
    logic        m_en;
    logic [2:0]  m_ps;
    logic [6:0]  m_psc;
    logic [15:0] m_cnt;
    logic [7:0]  m_mode, m_pq, m_pqq;
    logic [15:0] m_edge;
    logic [15:0] m_cap [8];

    function automatic logic exp_edge(logic [1:0] sel, logic now, logic prev);
        if (sel == 2'b01) return now && !prev;
        if (sel == 2'b10) return !now && prev;
        if (sel == 2'b11) return now != prev;
        return 1'b0;
    endfunction

    function automatic logic exp_act(logic [1:0] a, logic cur);
        if (a == 2'b01) return !cur;
        if (a == 2'b10) return 1'b0;
        if (a == 2'b11) return 1'b1;
        return cur;
    endfunction

    always @(posedge clk) begin
        logic [6:0] msk;
        logic       tk;
        if (rst) begin
            m_en <= 0; m_ps <= 0; m_psc <= 0; m_cnt <= 0;
            m_mode <= 0; m_edge <= 0; m_pq <= 0; m_pqq <= 0;
            for (int c = 0; c < 8; c++) m_cap[c] <= '0;
        end else begin
            msk = 7'((8'd1 << m_ps) - 8'd1);
            tk  = m_en && ((m_psc & msk) == msk);
            m_psc <= m_en ? m_psc + 7'd1 : 7'd0;
            if (tk) m_cnt <= m_cnt + 16'd1;
            for (int c = 0; c < 8; c++) begin
                if (m_en && !m_mode[c] && exp_edge(m_edge[2*c +: 2], m_pq[c], m_pqq[c]))
                    m_cap[c] <= m_cnt;
                else if (bus_wr && bus_addr == 4'(8 + c))
                    m_cap[c] <= bus_wdata;
            end
            m_pq  <= ch_in;
            m_pqq <= m_pq;
            if (bus_wr && bus_addr == 4'd0) begin m_en <= bus_wdata[0]; m_ps <= bus_wdata[3:1]; end
            if (bus_wr && bus_addr == 4'd1) m_mode <= bus_wdata[7:0];
            if (bus_wr && bus_addr == 4'd2) m_edge <= bus_wdata;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b0;
        #1 d = bus_rdata;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(4 * 190000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired, actual hung expected done");
        finish_run();
    end

    initial begin
        logic [15:0] d, flags_before, cmp;
        logic [15:0] exp_reg [8];
        logic b0, b2, b7;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), d);
            check("R1 register zero after reset", d, 0);
        end
        check("R1 ch_out/ch_oe/flags", {ch_out, ch_oe, ch_flags, 7'b0, ovf_flag}, 0);

        // R10: readback, timer disabled
        exp_reg[0] = 16'($urandom() & 16'hE);
        exp_reg[1] = 16'($urandom() & 16'hFF);
        exp_reg[2] = 16'($urandom());
        exp_reg[3] = 16'($urandom());
        exp_reg[4] = 16'($urandom());
        exp_reg[5] = 16'($urandom() & 16'hFF);
        for (int a = 0; a < 6; a++) wr(4'(a), exp_reg[a]);
        for (int a = 0; a < 6; a++) begin
            rd(4'(a), d);
            check("R10 config readback", d, exp_reg[a]);
        end
        for (int c = 0; c < 8; c++) begin
            cmp = 16'($urandom());
            wr(4'(8 + c), cmp);
            rd(4'(8 + c), d);
            check("R10 channel register readback", d, cmp);
        end
        for (int a = 0; a < 6; a++) wr(4'(a), 16'h0);

        // R2: prescaler and counter
        for (int t = 0; t < 6; t++) begin
            logic [2:0] ps;
            ps = 3'($urandom());
            wr(4'd0, {12'b0, ps, 1'b1});
            repeat (10 + $urandom() % 300) @(negedge clk);
            rd(4'd7, d);
            check("R2 counter under prescaler", d, m_cnt);
        end
        wr(4'd0, 16'h0);
        rd(4'd7, cmp);
        repeat (25) @(negedge clk);
        rd(4'd7, d);
        check("R2 counter holds while disabled", d, cmp);

        // R5/R6: compare match and actions
        wr(4'd0, {12'b0, 3'($urandom() % 3), 1'b1});
        for (int i = 0; i < 7; i++) begin
            logic [1:0] a;
            a = 2'($urandom());
            wr(4'd6, 16'h1FF);
            wr(4'd1, 16'(1 << i));
            wr(4'd3, 16'(a) << (2 * i));
            cmp = m_cnt + 16'd20 + 16'($urandom() % 30);
            wr(4'(8 + i), cmp);
            check("R5 output enable in compare mode", ch_oe, 8'(1 << i));
            b0 = ch_out[i];
            check("R5 flag clear before match", ch_flags[i], 0);
            while (m_cnt != cmp) @(negedge clk);
            check("R5 flag set on match", ch_flags[i], 1);
            check("R6 output action on match", ch_out[i], exp_act(a, b0));
        end

        // R8: flag clearing gated by enable
        rd(4'd6, flags_before);
        wr(4'd0, 16'h0);
        wr(4'd6, 16'h1FF);
        rd(4'd6, d);
        check("R8 clear ignored while disabled", d, flags_before);
        wr(4'd0, 16'h1);
        wr(4'd6, 16'h1FF);
        rd(4'd6, d);
        check("R8 clear while enabled", d, 0);

        // R7: channel 7 override
        for (int t = 0; t < 4; t++) begin
            logic [1:0] v;
            v = 2'($urandom());
            wr(4'd1, 16'h0087);
            wr(4'd3, 16'h4003);
            wr(4'd4, {6'b0, v, 8'h03});
            cmp = m_cnt + 16'd40;
            wr(4'd15, cmp);
            wr(4'd8, cmp);
            wr(4'd9, m_cnt - 16'd1);
            wr(4'd10, m_cnt - 16'd1);
            b2 = ch_out[2];
            b7 = ch_out[7];
            while (m_cnt != cmp) @(negedge clk);
            check("R7 masked channels forced", ch_out[1:0], v);
            check("R7 unmasked channel unchanged", ch_out[2], b2);
            check("R6 channel 7 own toggle", ch_out[7], !b7);
        end

        // R4: capture edges
        wr(4'd1, 16'h0);
        wr(4'd4, 16'h0);
        for (int t = 0; t < 8; t++) begin
            int c;
            logic [1:0] sel;
            logic lvl, hit;
            c = $urandom() % 8;
            sel = 2'($urandom());
            lvl = ch_in[c];
            wr(4'd2, 16'(sel) << (2 * c));
            repeat (4) @(negedge clk);
            wr(4'd6, 16'h1FF);
            ch_in[c] = !lvl;
            hit = exp_edge(sel, !lvl, lvl);
            repeat (4) @(negedge clk);
            check("R4 capture flag", ch_flags[c], hit);
            rd(4'(8 + c), d);
            check("R4 captured value", d, m_cap[c]);
        end
        wr(4'd2, 16'h0);

        // R3/R9: wrap sets overflow and toggles selected output
        wr(4'd1, 16'h0004);
        wr(4'd3, 16'h0000);
        wr(4'd5, 16'h0004);
        wr(4'd0, 16'h0001);
        wr(4'd6, 16'h1FF);
        b2 = ch_out[2];
        while (m_cnt != 16'hFFFF) @(negedge clk);
        check("R3 overflow clear before wrap", ovf_flag, 0);
        check("R9 output before wrap", ch_out[2], b2);
        @(negedge clk);
        check("R3 overflow flag on wrap", ovf_flag, 1);
        check("R9 toggle on overflow", ch_out[2], !b2);
        rd(4'd6, d);
        check("R3 overflow bit 8 in FLAGS", d[8], 1);

        finish_run();
    end
endmodule